// File: doc/BRIEF.md
# Per-Input Pattern Sense Reducer

This block compares a wide vector of monitored signals against a programmable per-signal sense pattern and folds the result into two registered flags. The first is an AND result, which is true when every participating signal matches its programmed polarity. The second is an OR result, which is true when any participating signal matches. One instance serves one priority slot of one step inside a larger trigger-sequencing engine. Condition logic downstream picks up the two flags.

Each monitored signal has a 2-bit sense code. Codes are loaded as 32-bit configuration words through a plain write port: a write enable, a word address and the data. One word holds the codes for eight consecutive signals, and as many words as needed cover the whole vector. A mode input replaces each signal's level with a change flag. The change flag is the current value XOR the value sampled at the previous clock edge, so the same pattern logic can detect transitions.

Top module: `sense_reducer`

## Requirements
- R1: Configuration word `w` carries the code for input `8w+k` (k = 0..7) in data bits `[4k+1:4k]`. Data bits `[4k+3:4k+2]` are ignored, and a write changes only the eight codes of the addressed word.
- R2: Code 2'b11 makes an input true when it reads 1, and code 2'b10 makes it true when it reads 0. In both cases the truth value feeds the AND result and the OR result.
- R3: Code 2'b01 removes an input from both results: it contributes 1 to the AND and 0 to the OR.
- R4: Code 2'b00 removes an input from the OR result and holds the AND result low.
- R5: While `rst_n` is low, or at the first clock edge on which it is sampled low, every code becomes 2'b01, `and_out` becomes 1, `or_out` becomes 0 and the stored previous sample becomes 0.
- R6: `and_out` and `or_out` change at the clock edge that samples `sense_in`, so the latency is one cycle. A code written at one edge governs the result formed at the next edge.
- R7: Writes to a word address at or above the number of words are ignored. Codes in the last word for inputs beyond `N_INPUTS` have no effect.
- R8: With `edge_mode` high, the value that each input presents to its code is `sense_in` XOR the `sense_in` sampled at the previous edge. With `edge_mode` low, the value is the level of `sense_in`.
- R9: Word 0 set to 0x11113232 with every other code at 2'b01 gives `and_out` = 1 exactly when `sense_in[3:0]` = 4'b1010.
- R10: With every code at 2'b11 and `edge_mode` high, `or_out` rises one cycle after any single input toggles, and stays low while all inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for a configuration word |
| cfg_addr | input | 5 | Word address, width derived from `N_INPUTS` |
| cfg_wdata | input | 32 | Configuration word: eight 2-bit codes, one per nibble |
| edge_mode | input | 1 | High selects change flags, low selects levels |
| sense_in | input | 140 | Monitored signal vector (`N_INPUTS`) |
| and_out | output | 1 | Registered AND of the per-input results |
| or_out | output | 1 | Registered OR of the per-input results |

## Verification
The assertions run on every cycle and cover the following:
- stability of codes across writes to other words or to addresses out of range, and the landing of written fields;
- the previous-sample register tracking the input and giving zero change flags while inputs hold;
- the all-neutral configuration holding AND high and OR low;
- any 2'b00 code forcing AND low;
- the reset values.

Only the directed scenarios can show the following:
- the exact polarity of each code against real input patterns;
- the one-cycle latency and when new codes take effect;
- the 0xA pattern match;
- transition detection through the OR flag;
- the ignored upper nibble bits and the ignored padding lanes.

// File: rtl/psr_pkg.sv
// Shared constants, code encoding and per-lane contribution functions for
// the sense reducer. Assumes eight 2-bit codes per 32-bit word, one per nibble.
package psr_pkg;

    localparam int WORD_W       = 32;
    localparam int LANES_PER_WD = 8;
    localparam int NIBBLE_W     = 4;

    typedef enum logic [1:0] {
        CODE_OR_SKIP  = 2'b00,
        CODE_AND_SKIP = 2'b01,
        CODE_MATCH_LO = 2'b10,
        CODE_MATCH_HI = 2'b11
    } sense_code_e;

    // Number of words needed to hold n lanes.
    function automatic int words_for(input int n);
        return (n + LANES_PER_WD - 1) / LANES_PER_WD;
    endfunction

    // Address width for n lanes, at least one bit.
    function automatic int addr_bits(input int n);
        return (words_for(n) > 1) ? $clog2(words_for(n)) : 1;
    endfunction

    // Contribution of one lane to the AND reduction.
    function automatic logic and_term(input logic [1:0] code, input logic v);
        case (code)
            CODE_OR_SKIP:  return 1'b0;
            CODE_AND_SKIP: return 1'b1;
            CODE_MATCH_LO: return ~v;
            default:       return v;
        endcase
    endfunction

    // Contribution of one lane to the OR reduction.
    function automatic logic or_term(input logic [1:0] code, input logic v);
        case (code)
            CODE_OR_SKIP:  return 1'b0;
            CODE_AND_SKIP: return 1'b0;
            CODE_MATCH_LO: return ~v;
            default:       return v;
        endcase
    endfunction

endpackage

// File: rtl/psr_select_bank.sv
// Holds one 2-bit sense code per lane, loaded eight at a time from 32-bit
// words. Assumes the address is a word index; out-of-range words match no lane.
module psr_select_bank #(
    parameter int N_LANES = 140,
    parameter int ADDR_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [psr_pkg::WORD_W-1:0] wr_data,
    output logic [N_LANES-1:0][1:0]    codes
);
    import psr_pkg::*;

    localparam int NUM_WORDS = words_for(N_LANES);
    localparam logic [31:0] WORDS32 = NUM_WORDS;

    logic [N_LANES-1:0][1:0] code_q;
    logic                    armed_q;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int WIDX = i / LANES_PER_WD;
        localparam int LIDX = i % LANES_PER_WD;
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(WIDX);

        // Load this lane's code when its word is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_q[i] <= CODE_AND_SKIP;
            else if (wr_en && wr_addr == WADDR)
                code_q[i] <= wr_data[NIBBLE_W*LIDX +: 2];
        end

        assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_addr == WADDR |=> code_q[i] == $past(wr_data[NIBBLE_W*LIDX +: 2]));

        assert_other_word_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q && wr_en && wr_addr != WADDR |=> $stable(code_q[i]));
    end

    // Marks the first cycle whose history lies wholly after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign codes = code_q;

    logic [31:0] addr_wide;
    assign addr_wide = 32'(wr_addr);

    assert_oob_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && wr_en && addr_wide >= WORDS32 |=> $stable(code_q));

endmodule

// File: rtl/psr_edge_front.sv
// Registers the inputs once and presents either their levels or their
// change flags (current XOR previous sample). Previous sample resets to 0.
module psr_edge_front #(
    parameter int N_LANES = 140
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               edge_mode,
    input  logic [N_LANES-1:0] sense_in,
    output logic [N_LANES-1:0] lane_val
);
    logic [N_LANES-1:0] prev_q;
    logic               armed_q;

    // Capture the inputs for the next cycle's change flags.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sense_in;
    end

    // Select level or change flag per lane.
    always_comb begin
        lane_val = edge_mode ? (sense_in ^ prev_q) : sense_in;
    end

    // Marks the first cycle whose history lies wholly after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_prev_tracks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> prev_q == $past(sense_in));

    assert_quiet_inputs_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && edge_mode && $stable(sense_in) |-> lane_val == '0);

endmodule

// File: rtl/psr_reduce.sv
// Combinational per-lane contribution and wide AND / OR reduction.
// Assumes codes and lane values arrive aligned lane for lane.
module psr_reduce #(
    parameter int N_LANES = 140
) (
    input  logic [N_LANES-1:0][1:0] codes,
    input  logic [N_LANES-1:0]      lane_val,
    output logic                    and_c,
    output logic                    or_c
);
    import psr_pkg::*;

    logic [N_LANES-1:0] and_terms;
    logic [N_LANES-1:0] or_terms;

    for (genvar i = 0; i < N_LANES; i++) begin : g_term
        // Map one lane's code and value to its two contributions.
        always_comb begin
            and_terms[i] = and_term(codes[i], lane_val[i]);
            or_terms[i]  = or_term(codes[i], lane_val[i]);
        end
    end

    // Fold all lanes into the two results.
    always_comb begin
        and_c = &and_terms;
        or_c  = |or_terms;
    end

endmodule

// File: rtl/sense_reducer.sv
// Top of the per-input pattern sense reducer: code bank, optional change
// front end, reduction, and registered AND / OR outputs (one-cycle latency).
module sense_reducer #(
    parameter int  N_INPUTS  = 140,
    localparam int NUM_WORDS = psr_pkg::words_for(N_INPUTS),
    localparam int ADDR_W    = psr_pkg::addr_bits(N_INPUTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 edge_mode,
    input  logic [N_INPUTS-1:0]  sense_in,
    output logic                 and_out,
    output logic                 or_out
);
    import psr_pkg::*;

    logic [N_INPUTS-1:0][1:0] codes;
    logic [N_INPUTS-1:0]      lane_val;
    logic                     and_c;
    logic                     or_c;
    logic                     and_q;
    logic                     or_q;

    psr_select_bank #(.N_LANES(N_INPUTS), .ADDR_W(ADDR_W)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .codes   (codes)
    );

    psr_edge_front #(.N_LANES(N_INPUTS)) i_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_mode (edge_mode),
        .sense_in  (sense_in),
        .lane_val  (lane_val)
    );

    psr_reduce #(.N_LANES(N_INPUTS)) i_reduce (
        .codes    (codes),
        .lane_val (lane_val),
        .and_c    (and_c),
        .or_c     (or_c)
    );

    // Register both reduced results; reset to the neutral pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            and_q <= 1'b1;
            or_q  <= 1'b0;
        end else begin
            and_q <= and_c;
            or_q  <= or_c;
        end
    end

    assign and_out = and_q;
    assign or_out  = or_q;

    // Checker helpers drawn from the code bank, separate from the reducer.
    logic [N_INPUTS-1:0] lane_neutral;
    logic [N_INPUTS-1:0] lane_blocks;
    logic                armed_q;

    for (genvar i = 0; i < N_INPUTS; i++) begin : g_chk
        assign lane_neutral[i] = (codes[i] == CODE_AND_SKIP);
        assign lane_blocks[i]  = (codes[i] == CODE_OR_SKIP);
    end

    // Marks the first cycle whose history lies wholly after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_neutral_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(&lane_neutral) |-> and_out && !or_out);

    assert_orskip_blocks_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(|lane_blocks) |-> !and_out);

    assert_reset_values_R5: assert property (@(posedge clk)
        !rst_n |=> and_out && !or_out && (&lane_neutral));

endmodule

// File: tb/test_sense_reducer.sv
// Directed bench for sense_reducer: one task per scenario, each checking
// its own results against a model built from the requirements.
module test_sense_reducer;

    localparam int N  = 140;
    localparam int NW = 18;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [31:0]   cfg_wdata;
    logic          edge_mode;
    logic [N-1:0]  sense_in;
    logic          and_out;
    logic          or_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [1:0]   shadow [N];
    logic [N-1:0] tb_prev;

    always #2 clk = ~clk;

    sense_reducer #(.N_INPUTS(N)) i_sense_reducer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .edge_mode (edge_mode),
        .sense_in  (sense_in),
        .and_out   (and_out),
        .or_out    (or_out)
    );

    task automatic check(input string req, input logic a_exp, input logic o_exp);
        n_checks++;
        if (and_out !== a_exp || or_out !== o_exp) begin
            n_fails++;
            $display("FAIL %s: and_out/or_out actual %b/%b expected %b/%b",
                     req, and_out, or_out, a_exp, o_exp);
        end
    endtask

    task automatic model(input logic [N-1:0] v, output logic a, output logic o);
        a = 1'b1;
        o = 1'b0;
        for (int i = 0; i < N; i++) begin
            logic x;
            x = edge_mode ? (v[i] ^ tb_prev[i]) : v[i];
            case (shadow[i])
                2'b00: a = 1'b0;
                2'b01: ;
                2'b10: begin a = a & ~x; o = o | ~x; end
                default: begin a = a & x; o = o | x; end
            endcase
        end
    endtask

    // Drive one input vector at a falling edge and check after the next rise.
    task automatic step(input string req, input logic [N-1:0] v);
        logic a, o;
        sense_in = v;
        model(v, a, o);
        @(posedge clk);
        tb_prev = v;
        @(negedge clk);
        check(req, a, o);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(addr);
        cfg_wdata = data;
        @(posedge clk);
        tb_prev = sense_in;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < NW)
            for (int k = 0; k < 8; k++)
                if (8*addr + k < N) shadow[8*addr + k] = data[4*k +: 2];
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_we = 1'b0;
        cfg_addr = '0;
        cfg_wdata = '0;
        edge_mode = 1'b0;
        sense_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) shadow[i] = 2'b01;
        tb_prev = '0;
    endtask

    function automatic logic [N-1:0] rand_vec();
        logic [N-1:0] r;
        for (int w = 0; w < (N + 31) / 32; w++)
            for (int b = 0; b < 32; b++)
                if (32*w + b < N) r[32*w + b] = 1'(($urandom >> b) & 1);
        return r;
    endfunction

    task automatic t_reset_state();
        do_reset();
        check("R5 reset values", 1'b1, 1'b0);
        step("R3 all neutral", rand_vec());
        step("R3 all neutral ones", '1);
    endtask

    task automatic t_pattern_a();
        wr(0, 32'h1111_3232);
        step("R9 0xA match", {rand_vec() >> 4, 4'b1010});
        step("R9 0xB no match", {rand_vec() >> 4, 4'b1011});
        step("R9 zero no match", '0);
        step("R6 back to match", {{(N-4){1'b1}}, 4'b1010});
    endtask

    task automatic t_polarity();
        do_reset();
        wr(3, 32'h1111_1113);
        step("R2 high code sees 1", N'(1) << 24);
        step("R2 high code sees 0", '0);
        wr(3, 32'h1111_1112);
        step("R2 low code sees 0", '0);
        step("R2 low code sees 1", N'(1) << 24);
    endtask

    task automatic t_or_skip();
        do_reset();
        wr(5, 32'h1111_1110);
        step("R4 or-skip blocks and", '1);
        step("R4 or-skip blocks and zeros", '0);
        wr(5, 32'h1111_1130);
        step("R4 or still fed by sensed lane", N'(1) << 41);
    endtask

    task automatic t_nibble_and_bounds();
        do_reset();
        wr(2, 32'hEEEE_EEEE);
        step("R1 upper nibble bits ignored", '0);
        step("R1 lane16 low code sees 1", N'(1) << 16);
        do_reset();
        wr(17, 32'h0000_1111);
        step("R7 padding lanes no effect", rand_vec());
        wr(18, 32'h0000_0000);
        wr(31, 32'h0000_0000);
        step("R7 out of range write ignored", rand_vec());
        wr(17, 32'h0000_3000);
        step("R1 last real lane 139 sensed", N'(1) << 139);
    endtask

    task automatic t_random_codes();
        do_reset();
        for (int r = 0; r < 30; r++) begin
            if (r % 5 == 0)
                for (int w = 0; w < NW; w++) wr(w, $urandom | 32'h1111_1111);
            step("R2 random pattern", rand_vec());
        end
        for (int w = 0; w < NW; w++) wr(w, 32'h1111_1111);
        step("R6 new codes apply next edge", rand_vec());
    endtask

    task automatic t_edges();
        do_reset();
        for (int w = 0; w < NW; w++) wr(w, 32'h3333_3333);
        edge_mode = 1'b1;
        step("R5 prev sample zero", N'(1) << 7);
        step("R10 hold quiet", N'(1) << 7);
        step("R10 toggle lane 139", (N'(1) << 7) | (N'(1) << 139));
        step("R10 hold quiet again", (N'(1) << 7) | (N'(1) << 139));
        step("R10 toggle lane 7", N'(1) << 139);
        wr(0, 32'h1111_1112);
        step("R8 low code with no change", N'(1) << 139);
        edge_mode = 1'b0;
        step("R8 level mode", N'(1) << 139);
        edge_mode = 1'b1;
        for (int r = 0; r < 10; r++) step("R8 random edges", rand_vec());
    endtask

    initial begin
        t_reset_state();
        t_pattern_a();
        t_polarity();
        t_or_skip();
        t_nibble_and_bounds();
        t_random_codes();
        t_edges();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule